// File: doc/BRIEF.md
# Sleep Mode and Wake Controller

This block decides which clock domains of a small microcontroller keep running after the CPU executes its sleep instruction, and it decides when the core is released again. The CPU supplies a two-bit mode select, a sleep enable and a one-cycle sleep strobe. The block drives clock-gate enables for the CPU, I/O, flash and ADC domains and a run request for the main oscillator. It passes only the wake events that the latched mode allows. It fires an ADC start pulse on entry to noise-reduction mode. It can also switch off the brown-out detector during power-down.

Turning off the brown-out detector requires a protected configuration bit that can only be written through a short unlock sequence. After a power-down wake the core stays held while a start-up counter runs. The normal delay applies when the detector stayed on, and the longer reset-grade delay applies when it was switched off. Idle and noise-reduction sleeps resume on the cycle after the wake event. The oscillator, detector, ADC, interrupt logic and fuses are outside the block; they appear only as ports.

Top module: `slpctl_top`

## Requirements
- R1: After reset, all four clock enables and `osc_run` are 1, `adc_start` is 0, `bod_off_cfg` is 0, and `bod_en` follows `bod_fuse_en`.
- R2: A sleep strobe with `sleep_en`=1 and `mode_sel`=00 enters idle from the next cycle. In idle, the CPU and flash enables are 0 and the I/O, ADC and oscillator outputs stay 1.
- R3: With `mode_sel`=01 the block enters noise-reduction sleep. In this mode the CPU, I/O and flash enables are 0, and the ADC enable and `osc_run` stay 1.
- R4: With `mode_sel`=10 the block enters power-down, and all four clock enables and `osc_run` are 0.
- R5: On entry to noise-reduction sleep, `adc_start` is 1 for exactly one cycle if `adc_en` was 1. There is no pulse when `adc_en` is 0 or when the block enters another mode.
- R6: The `wake_src` bits are: 0 ADC done, 1 external reset, 2 watchdog reset, 3 brown-out reset, 4 NVM ready, 5 INT0 level, 6 pin change, 7 serial start condition. Idle wakes on any bit. Noise-reduction wakes on bits 0 to 6. Power-down wakes on bits 1, 2, 3, 5, 6 and 7 only.
- R7: A sleep strobe while `sleep_en` is 0 leaves every output unchanged.
- R8: `bod_off_cfg` changes only when two writes arrive in order. The first write has `cfg_bod_off`=1 and `cfg_unlock`=1. The second write has `cfg_unlock`=0 and arrives 1 to 4 cycles after the first. The second write sets the bit to its `cfg_bod_off` value.
- R9: If the second write comes 5 or more cycles after the unlock write, it is ignored. A write with `cfg_unlock`=0 and no unlock before it is also ignored.
- R10: `bod_en` is 0 only while the block sleeps in power-down entered with `bod_off_cfg`=1. In every other case it follows `bod_fuse_en`, and it returns on the cycle after the wake event.
- R11: After a power-down wake, only `osc_run` is 1 for WAKE_DLY cycles when the detector stayed on, or for RST_DLY cycles when it was cut. After that wait all enables return to 1.
- R12: A wake from idle or noise-reduction sleep restores all enables on the cycle after the wake event.
- R13: `mode_sel`=11 behaves exactly as idle, both in its clock enables and in its wake sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Sleep mode select, sampled on the sleep strobe |
| sleep_en | input | 1 | Sleep enable; a strobe is ignored when this is 0 |
| sleep_strobe | input | 1 | One-cycle sleep instruction pulse from the CPU |
| adc_en | input | 1 | ADC enabled |
| bod_fuse_en | input | 1 | Brown-out detector enabled by configuration fuse |
| cfg_wr | input | 1 | Write strobe for the detector-cut configuration |
| cfg_bod_off | input | 1 | Write data: cut detector during power-down |
| cfg_unlock | input | 1 | Write data: unlock bit of the timed sequence |
| wake_src | input | 8 | Wake events, bit order as in R6 |
| clk_en_cpu | output | 1 | CPU clock gate enable |
| clk_en_io | output | 1 | I/O clock gate enable |
| clk_en_flash | output | 1 | Flash clock gate enable |
| clk_en_adc | output | 1 | ADC clock gate enable |
| osc_run | output | 1 | Main oscillator run request |
| adc_start | output | 1 | One-cycle ADC start pulse |
| bod_en | output | 1 | Brown-out detector enable |
| bod_off_cfg | output | 1 | Current value of the protected detector-cut bit |

## Verification
The hardest case to reach is the long start-up path. To reach it, the protected bit must first be set through an unlock write followed by a second write within the window. Then the block must enter power-down and receive a wake source that power-down accepts. The bench runs the timed sequence at gaps of exactly four and five cycles to land on both sides of the window edge. It then sleeps and wakes with the bit set and with it clear, and samples the core release one cycle before and one cycle at the expected count for each delay.

// File: rtl/slp_pkg.sv
package slp_pkg;
  typedef enum logic [1:0] {ST_RUN, ST_SLEEP, ST_WAIT} slp_state_e;

  localparam logic [1:0] MODE_IDLE  = 2'b00;
  localparam logic [1:0] MODE_ADCNR = 2'b01;
  localparam logic [1:0] MODE_PDOWN = 2'b10;
  localparam int         NUM_WAKE   = 8;

  typedef struct packed {
    logic cpu;
    logic io;
    logic flash;
    logic adc;
    logic osc;
  } clk_gate_t;

  function automatic logic [NUM_WAKE-1:0] wake_allow(input logic [1:0] mode);
    case (mode)
      MODE_ADCNR: wake_allow = 8'h7F;
      MODE_PDOWN: wake_allow = 8'hEE;
      default:    wake_allow = 8'hFF;
    endcase
  endfunction

  function automatic clk_gate_t gates_for(input slp_state_e st, input logic [1:0] mode);
    clk_gate_t g;
    g = '{cpu: 1'b1, io: 1'b1, flash: 1'b1, adc: 1'b1, osc: 1'b1};
    if (st == ST_WAIT) begin
      g = '{cpu: 1'b0, io: 1'b0, flash: 1'b0, adc: 1'b0, osc: 1'b1};
    end else if (st == ST_SLEEP) begin
      case (mode)
        MODE_ADCNR: g = '{cpu: 1'b0, io: 1'b0, flash: 1'b0, adc: 1'b1, osc: 1'b1};
        MODE_PDOWN: g = '{cpu: 1'b0, io: 1'b0, flash: 1'b0, adc: 1'b0, osc: 1'b0};
        default:    g = '{cpu: 1'b0, io: 1'b1, flash: 1'b0, adc: 1'b1, osc: 1'b1};
      endcase
    end
    return g;
  endfunction
endpackage

// File: rtl/slp_bod_cfg.sv
module slp_bod_cfg #(
  parameter int TWIN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic wdata,
  input  logic unlock,
  output logic bods_q
);
  localparam int WW = $clog2(TWIN + 1);

  logic          armed_q;
  logic [WW-1:0] win_q;
  logic          arm_req;
  logic          commit;

  assign arm_req = wr && unlock && wdata;
  assign commit  = wr && !unlock && armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bods_q  <= 1'b0;
      armed_q <= 1'b0;
      win_q   <= '0;
    end else if (arm_req) begin
      armed_q <= 1'b1;
      win_q   <= WW'(TWIN);
    end else if (commit) begin
      bods_q  <= wdata;
      armed_q <= 1'b0;
    end else if (armed_q) begin
      if (win_q == WW'(1)) armed_q <= 1'b0;
      win_q <= win_q - 1'b1;
    end
  end

  assert_bods_guarded_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(bods_q) |-> ($past(armed_q) && $past(wr) && !$past(unlock)));
  assert_window_bound_R9: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> (win_q != '0 && win_q <= WW'(TWIN)));
endmodule

// File: rtl/slp_wake_mask.sv
module slp_wake_mask
  import slp_pkg::*;
(
  input  logic [1:0]          mode,
  input  logic [NUM_WAKE-1:0] src,
  output logic                hit
);
  logic [NUM_WAKE-1:0] allowed;

  always_comb begin
    allowed = src & wake_allow(mode);
    hit     = |allowed;
  end
endmodule

// File: rtl/slp_wake_timer.sv
module slp_wake_timer #(
  parameter int WAKE_DLY = 6,
  parameter int RST_DLY  = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic long_sel,
  output logic busy,
  output logic last
);
  localparam int MAXD = (RST_DLY > WAKE_DLY) ? RST_DLY : WAKE_DLY;
  localparam int CW   = $clog2(MAXD + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= long_sel ? CW'(RST_DLY - 1) : CW'(WAKE_DLY - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy = busy_q;
  assign last = busy_q && (cnt_q == '0);

  assert_count_bound_R11: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (cnt_q <= CW'(MAXD - 1)));
  assert_count_steps_R11: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cnt_q != '0 && !start) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/slpctl_top.sv
module slpctl_top
  import slp_pkg::*;
#(
  parameter int WAKE_DLY = 6,
  parameter int RST_DLY  = 16,
  parameter int TWIN     = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_sel,
  input  logic       sleep_en,
  input  logic       sleep_strobe,
  input  logic       adc_en,
  input  logic       bod_fuse_en,
  input  logic       cfg_wr,
  input  logic       cfg_bod_off,
  input  logic       cfg_unlock,
  input  logic [7:0] wake_src,
  output logic       clk_en_cpu,
  output logic       clk_en_io,
  output logic       clk_en_flash,
  output logic       clk_en_adc,
  output logic       osc_run,
  output logic       adc_start,
  output logic       bod_en,
  output logic       bod_off_cfg
);
  slp_state_e state_q, state_d;
  logic [1:0] mode_q, mode_d;
  logic       cut_q, cut_d;
  logic       enter, wake_hit, tmr_start, tmr_busy, tmr_last;
  clk_gate_t  gate_q;
  logic       adc_start_q, bod_en_q;

  slp_bod_cfg #(.TWIN(TWIN)) u_cfg (
    .clk(clk), .rst(rst), .wr(cfg_wr), .wdata(cfg_bod_off),
    .unlock(cfg_unlock), .bods_q(bod_off_cfg)
  );

  slp_wake_mask u_mask (.mode(mode_q), .src(wake_src), .hit(wake_hit));

  slp_wake_timer #(.WAKE_DLY(WAKE_DLY), .RST_DLY(RST_DLY)) u_tmr (
    .clk(clk), .rst(rst), .start(tmr_start), .long_sel(cut_q),
    .busy(tmr_busy), .last(tmr_last)
  );

  assign enter = (state_q == ST_RUN) && sleep_strobe && sleep_en;

  always_comb begin
    state_d   = state_q;
    mode_d    = mode_q;
    cut_d     = cut_q;
    tmr_start = 1'b0;
    case (state_q)
      ST_RUN: if (enter) begin
        state_d = ST_SLEEP;
        mode_d  = mode_sel;
        cut_d   = (mode_sel == MODE_PDOWN) && bod_off_cfg && bod_fuse_en;
      end
      ST_SLEEP: if (wake_hit) begin
        if (mode_q == MODE_PDOWN) begin
          state_d   = ST_WAIT;
          tmr_start = 1'b1;
        end else begin
          state_d = ST_RUN;
        end
        cut_d = 1'b0;
      end
      ST_WAIT: if (tmr_last) state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_RUN;
      mode_q      <= MODE_IDLE;
      cut_q       <= 1'b0;
      gate_q      <= '{cpu: 1'b1, io: 1'b1, flash: 1'b1, adc: 1'b1, osc: 1'b1};
      adc_start_q <= 1'b0;
      bod_en_q    <= bod_fuse_en;
    end else begin
      state_q     <= state_d;
      mode_q      <= mode_d;
      cut_q       <= cut_d;
      gate_q      <= gates_for(state_d, mode_d);
      adc_start_q <= enter && (mode_sel == MODE_ADCNR) && adc_en;
      bod_en_q    <= bod_fuse_en && !((state_d == ST_SLEEP) && cut_d);
    end
  end

  assign clk_en_cpu   = gate_q.cpu;
  assign clk_en_io    = gate_q.io;
  assign clk_en_flash = gate_q.flash;
  assign clk_en_adc   = gate_q.adc;
  assign osc_run      = gate_q.osc;
  assign adc_start    = adc_start_q;
  assign bod_en       = bod_en_q;

  assert_strobe_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && sleep_strobe && !sleep_en) |=> (state_q == ST_RUN));
  assert_adc_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    adc_start_q |-> ($past(sleep_strobe) && $past(sleep_en) && $past(adc_en)
                     && $past(mode_sel) == MODE_ADCNR));
  assert_adc_single_R5: assert property (@(posedge clk) disable iff (rst)
    adc_start_q |=> !adc_start_q);
  assert_pdown_dark_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SLEEP && mode_q == MODE_PDOWN) |-> (gate_q == '0));
  assert_bod_cut_R10: assert property (@(posedge clk) disable iff (rst)
    (!bod_en_q && $past(bod_fuse_en)) |-> (state_q == ST_SLEEP && mode_q == MODE_PDOWN));
  assert_wait_timer_R11: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT) |-> tmr_busy);
endmodule

// File: tb/slpctl_top_tb.sv
module slpctl_top_tb;
  localparam int WAKE_DLY = 6;
  localparam int RST_DLY  = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode_sel = 2'b00;
  logic       sleep_en = 1'b0, sleep_strobe = 1'b0, adc_en = 1'b0, bod_fuse_en = 1'b1;
  logic       cfg_wr = 1'b0, cfg_bod_off = 1'b0, cfg_unlock = 1'b0;
  logic [7:0] wake_src = 8'h00;
  logic       clk_en_cpu, clk_en_io, clk_en_flash, clk_en_adc, osc_run, adc_start, bod_en, bod_off_cfg;
  int         n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  slpctl_top #(.WAKE_DLY(WAKE_DLY), .RST_DLY(RST_DLY), .TWIN(4)) u_dut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .sleep_en(sleep_en),
    .sleep_strobe(sleep_strobe), .adc_en(adc_en), .bod_fuse_en(bod_fuse_en),
    .cfg_wr(cfg_wr), .cfg_bod_off(cfg_bod_off), .cfg_unlock(cfg_unlock),
    .wake_src(wake_src), .clk_en_cpu(clk_en_cpu), .clk_en_io(clk_en_io),
    .clk_en_flash(clk_en_flash), .clk_en_adc(clk_en_adc), .osc_run(osc_run),
    .adc_start(adc_start), .bod_en(bod_en), .bod_off_cfg(bod_off_cfg)
  );

  // {mode[1:0], wake_src[7:0], expect_wake}
  localparam int NV = 14;
  localparam logic [10:0] VEC [NV] = '{
    {2'b00, 8'h80, 1'b1}, {2'b00, 8'h01, 1'b1}, {2'b00, 8'h10, 1'b1},
    {2'b01, 8'h01, 1'b1}, {2'b01, 8'h80, 1'b0}, {2'b01, 8'h10, 1'b1},
    {2'b01, 8'h40, 1'b1}, {2'b10, 8'h01, 1'b0}, {2'b10, 8'h10, 1'b0},
    {2'b10, 8'h80, 1'b1}, {2'b10, 8'h20, 1'b1}, {2'b10, 8'h08, 1'b1},
    {2'b11, 8'h01, 1'b1}, {2'b11, 8'h80, 1'b1}
  };

  function automatic logic [4:0] gates();
    return {clk_en_cpu, clk_en_io, clk_en_flash, clk_en_adc, osc_run};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic go_sleep(input logic [1:0] m, input logic en);
    mode_sel = m; sleep_en = en; sleep_strobe = 1'b1;
    @(negedge clk);
    sleep_strobe = 1'b0;
  endtask

  task automatic pulse_wake(input logic [7:0] s);
    wake_src = s;
    @(negedge clk);
    wake_src = 8'h00;
  endtask

  task automatic settle();
    repeat (RST_DLY + 2) @(negedge clk);
  endtask

  task automatic timed_write(input int gap, input logic val);
    cfg_wr = 1'b1; cfg_bod_off = 1'b1; cfg_unlock = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_unlock = 1'b0;
    repeat (gap - 1) @(negedge clk);
    cfg_wr = 1'b1; cfg_bod_off = val; cfg_unlock = 1'b0;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic check_delay(input string req, input int d);
    pulse_wake(8'h02);
    chk(req, {27'd0, gates()}, 32'h01);
    chk(req, bod_en, 1'b1);
    repeat (d - 1) @(negedge clk);
    chk(req, clk_en_cpu, 1'b0);
    @(negedge clk);
    chk(req, {27'd0, gates()}, 32'h1F);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 gates", {27'd0, gates()}, 32'h1F);
    chk("R1 adc_start", adc_start, 1'b0);
    chk("R1 cfg", bod_off_cfg, 1'b0);
    chk("R1 bod_en", bod_en, 1'b1);

    // R6 wake source table
    for (int i = 0; i < NV; i++) begin
      go_sleep(VEC[i][10:9], 1'b1);
      pulse_wake(VEC[i][8:1]);
      settle();
      chk($sformatf("R6 vec%0d", i), clk_en_cpu, VEC[i][0]);
      if (!VEC[i][0]) begin
        pulse_wake(8'h02);
        settle();
      end
    end

    // R2 idle, R12 immediate wake
    go_sleep(2'b00, 1'b1);
    chk("R2 idle gates", {27'd0, gates()}, 32'h0B);
    pulse_wake(8'h40);
    chk("R12 idle wake", {27'd0, gates()}, 32'h1F);

    // R13 mode 11
    go_sleep(2'b11, 1'b1);
    chk("R13 reserved gates", {27'd0, gates()}, 32'h0B);
    pulse_wake(8'h01);
    chk("R13 reserved wake", {27'd0, gates()}, 32'h1F);

    // R3 + R5 noise reduction with ADC enabled
    adc_en = 1'b1;
    go_sleep(2'b01, 1'b1);
    chk("R3 nr gates", {27'd0, gates()}, 32'h03);
    chk("R5 start pulse", adc_start, 1'b1);
    @(negedge clk);
    chk("R5 pulse width", adc_start, 1'b0);
    chk("R10 bod kept in nr", bod_en, 1'b1);
    pulse_wake(8'h01);
    chk("R12 nr wake", {27'd0, gates()}, 32'h1F);
    // R5 no pulse for idle or without adc_en
    go_sleep(2'b00, 1'b1);
    chk("R5 no pulse idle", adc_start, 1'b0);
    pulse_wake(8'h02);
    adc_en = 1'b0;
    go_sleep(2'b01, 1'b1);
    chk("R5 no pulse adc off", adc_start, 1'b0);
    pulse_wake(8'h02);

    // R7 strobe ignored with sleep_en 0
    go_sleep(2'b10, 1'b0);
    chk("R7 ignored", {27'd0, gates()}, 32'h1F);
    @(negedge clk);
    chk("R7 ignored later", {27'd0, gates()}, 32'h1F);

    // R4 power-down, R11 normal delay
    go_sleep(2'b10, 1'b1);
    chk("R4 pd gates", {27'd0, gates()}, 32'h00);
    chk("R10 bod kept cfg0", bod_en, 1'b1);
    check_delay("R11 normal", WAKE_DLY);

    // R9 write without unlock ignored, late write ignored
    cfg_wr = 1'b1; cfg_bod_off = 1'b1; cfg_unlock = 1'b0;
    @(negedge clk);
    cfg_wr = 1'b0;
    chk("R9 no unlock", bod_off_cfg, 1'b0);
    timed_write(5, 1'b1);
    chk("R9 late", bod_off_cfg, 1'b0);
    // R8 write at last allowed cycle
    timed_write(4, 1'b1);
    chk("R8 accepted", bod_off_cfg, 1'b1);

    // R10 cut during power-down, R11 reset delay
    go_sleep(2'b10, 1'b1);
    chk("R10 bod cut", bod_en, 1'b0);
    check_delay("R11 reset delay", RST_DLY);
    chk("R10 bod back", bod_en, 1'b1);

    // R10 cfg=1 does not cut in noise reduction
    go_sleep(2'b01, 1'b1);
    chk("R10 no cut nr", bod_en, 1'b1);
    pulse_wake(8'h02);

    // R8 clear the bit again at gap 1
    timed_write(1, 1'b0);
    chk("R8 cleared", bod_off_cfg, 1'b0);
    go_sleep(2'b10, 1'b1);
    chk("R10 no cut cfg0", bod_en, 1'b1);
    check_delay("R11 normal again", WAKE_DLY);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule